// File: doc/BRIEF.md
# Serial receiver with line status

This block is the receive half of an asynchronous serial port. It watches a serial input line that idles high, and it uses a 16x oversampling tick to find and confirm start bits. It then samples each following bit at its middle and assembles a character of five to eight bits. The character goes into a single holding register. The frame shape comes from the same line control byte that the companion transmitter uses, so one configuration write sets up both directions.

Next to the holding register the block keeps a line status byte. This byte reports data availability, overrun, parity, framing and break conditions, and a summary error bit. It also mirrors two status lines from the transmitter so that the host reads one byte for the state of the whole port. A one-cycle read strobe takes the character. A separate one-cycle strobe acknowledges the error flags.

Top module: `uart_rx_status`

## Requirements
- R1: A frame is a low start bit, then 5 to 8 data bits least significant first, then an optional parity bit, then a stop bit. The word length is set by line_cfg[1:0], where 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8 bits. Any unused upper bits of rx_data read as zero.
- R2: A start bit counts only if the line is still low when it is resampled at mid-bit, eight ticks after the falling edge is seen. A shorter low pulse is dropped, and the receiver returns to idle without delivering a word.
- R3: status[0] (data ready) rises only after the stop bit of a word has been sampled and the word has been moved into the holding register. A data_rd pulse clears it.
- R4: If a word completes while status[0] is set and no data_rd arrives in the same cycle, status[1] (overrun) is set. The new word replaces the held word.
- R5: line_cfg[3] turns parity on. With line_cfg[5] low, line_cfg[4] selects even parity when high and odd parity when low. With line_cfg[5] high (fixed parity), the expected parity bit is the inverse of line_cfg[4]. A received parity bit that differs from the expected value sets status[2].
- R6: status[3] (framing error) is set when the first stop bit is sampled low. Only the first stop bit is checked.
- R7: A frame whose every sampled bit is low, stop bit included, sets status[4] (break) together with status[3] and delivers the word 0x00. After that the receiver waits for the line to return high before it looks for a new start bit, so a long low period yields one word.
- R8: status[7] is high whenever any of status[2], status[3] or status[4] is held.
- R9: A status_rd pulse clears status[1] to status[4] and status[7] on the next cycle. It leaves status[0] unchanged. A new error that arrives in the same cycle as status_rd still gets recorded.
- R10: status[6] follows tx_empty_in and status[5] follows tx_hold_empty_in, with no delay.
- R11: After reset, rx_data is 0x00 and status bits 0 to 4 and bit 7 are zero.
- R12: line_cfg[6] and line_cfg[7] belong to the transmitter and have no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | One-cycle enable, sixteen per bit time |
| rx_in | input | 1 | Serial input, idles high |
| line_cfg | input | 8 | Line control byte shared with the transmitter |
| data_rd | input | 1 | Pops the held character |
| status_rd | input | 1 | Acknowledges the error flags |
| tx_empty_in | input | 1 | Transmitter fully idle, mirrored to status[6] |
| tx_hold_empty_in | input | 1 | Transmitter holding slot free, mirrored to status[5] |
| rx_data | output | 8 | Held character, right aligned |
| status | output | 8 | Line status byte |

## Verification
The assertions check the handshakes between the framer and the status register on every cycle. They confirm that data ready rises only after a completed word, that both read strobes clear their bits, that an unread word followed by a new one sets overrun, and that break never appears without framing error. Only the bench scenarios can show that bits are sampled at the right point and assembled in the right order. The same holds for parity in all three modes, for rejecting a glitch, for a long break producing a single zero word, and for the transmitter configuration bits being ignored. The bench checks each of these against frames it builds itself.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 8;

    // Line control byte; field positions are shared with the transmitter.
    typedef struct packed {
        logic       rsvd7;
        logic       tx_break;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } line_cfg_t;

    // Subset of the control byte the receiver latches per frame.
    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic [1:0] wlen;
    } rx_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD_LOW
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_word_t;

    typedef struct packed {
        logic err_any;
        logic tx_empty;
        logic thr_empty;
        logic brk;
        logic ferr;
        logic perr;
        logic ovr;
        logic ready;
    } line_stat_t;

    function automatic int unsigned word_bits(logic [1:0] wl);
        return 5 + int'(wl);
    endfunction

    function automatic logic want_parity(rx_cfg_t c, logic [DATA_W-1:0] d);
        if (c.stick)
            return ~c.even;
        return c.even ? ^d : ~^d;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx,
    input  line_cfg_t cfg,
    output logic      done,
    output rx_word_t  word
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int HALF  = OVERSAMPLE / 2;
    localparam int BIT_W = $clog2(DATA_W);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              all_low;
    rx_cfg_t           cfg_q;

    logic              bit_end;
    logic              half_end;
    logic [BIT_W-1:0]  last_idx;
    logic [BIT_W:0]    shamt;
    logic [DATA_W-1:0] aligned;
    logic              stop_low;
    logic              unused_cfg;

    assign unused_cfg = ^{cfg.rsvd7, cfg.tx_break, cfg.two_stop};

    always_comb begin
        bit_end  = (cnt == CNT_W'(OVERSAMPLE - 1));
        half_end = (cnt == CNT_W'(HALF - 1));
        last_idx = BIT_W'(word_bits(cfg_q.wlen) - 1);
        shamt    = (BIT_W+1)'(DATA_W - word_bits(cfg_q.wlen));
        aligned  = shreg >> shamt;
        stop_low = ~rx;
    end

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            all_low <= 1'b0;
            cfg_q   <= '0;
            word    <= '0;
        end else if (tick) begin
            case (state)
                ST_IDLE: begin
                    if (!rx) begin
                        state <= ST_START;
                        cnt   <= '0;
                        cfg_q <= '{stick: cfg.stick, even: cfg.even,
                                   par_en: cfg.par_en, wlen: cfg.wlen};
                    end
                end
                ST_START: begin
                    if (half_end) begin
                        cnt <= '0;
                        if (!rx) begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                            shreg   <= '0;
                            all_low <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) begin
                        shreg   <= {rx, shreg[DATA_W-1:1]};
                        all_low <= all_low & ~rx;
                        if (bit_idx == last_idx)
                            state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_PARITY: begin
                    cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) begin
                        par_bit <= rx;
                        all_low <= all_low & ~rx;
                        state   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    cnt <= bit_end ? '0 : cnt + 1'b1;
                    if (bit_end) begin
                        done      <= 1'b1;
                        word.data <= aligned;
                        word.perr <= cfg_q.par_en &&
                                     (par_bit != want_parity(cfg_q, aligned));
                        word.ferr <= stop_low;
                        word.brk  <= all_low & stop_low;
                        state     <= (all_low & stop_low) ? ST_HOLD_LOW : ST_IDLE;
                    end
                end
                ST_HOLD_LOW: begin
                    if (rx)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_word_t          word,
    input  logic              data_rd,
    input  logic              status_rd,
    input  logic              tx_empty,
    input  logic              thr_empty,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        status
);
    logic       ready, ovr, perr, ferr, brk;
    line_stat_t stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            ready   <= 1'b0;
            ovr     <= 1'b0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
            brk     <= 1'b0;
        end else begin
            if (done) begin
                rx_data <= word.data;
                ready   <= 1'b1;
            end else if (data_rd) begin
                ready <= 1'b0;
            end
            ovr  <= (done & ready & ~data_rd) | (ovr  & ~status_rd);
            perr <= (done & word.perr)        | (perr & ~status_rd);
            ferr <= (done & word.ferr)        | (ferr & ~status_rd);
            brk  <= (done & word.brk)         | (brk  & ~status_rd);
        end
    end

    always_comb begin
        stat.ready     = ready;
        stat.ovr       = ovr;
        stat.perr      = perr;
        stat.ferr      = ferr;
        stat.brk       = brk;
        stat.thr_empty = thr_empty;
        stat.tx_empty  = tx_empty;
        stat.err_any   = perr | ferr | brk;
        status         = stat;
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_16x,
    input  logic       rx_in,
    input  logic [7:0] line_cfg,
    input  logic       data_rd,
    input  logic       status_rd,
    input  logic       tx_empty_in,
    input  logic       tx_hold_empty_in,
    output logic [7:0] rx_data,
    output logic [7:0] status
);
    logic      rx_s;
    logic      frm_done;
    rx_word_t  frm_word;
    line_cfg_t cfg;

    assign cfg = line_cfg_t'(line_cfg);

    uart_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_in),
        .q   (rx_s)
    );

    uart_rx_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_16x),
        .rx   (rx_s),
        .cfg  (cfg),
        .done (frm_done),
        .word (frm_word)
    );

    uart_rx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .done      (frm_done),
        .word      (frm_word),
        .data_rd   (data_rd),
        .status_rd (status_rd),
        .tx_empty  (tx_empty_in),
        .thr_empty (tx_hold_empty_in),
        .rx_data   (rx_data),
        .status    (status)
    );
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       frm_done,
    input logic       data_rd,
    input logic       status_rd,
    input logic [7:0] status
);
    a_r3_ready_after_word: assert property (@(posedge clk) disable iff (rst)
        frm_done |=> status[0]);

    a_r3_ready_needs_word: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> $past(frm_done));

    a_r3_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !frm_done) |=> !status[0]);

    a_r4_overrun_flag: assert property (@(posedge clk) disable iff (rst)
        (frm_done && status[0] && !data_rd) |=> status[1]);

    a_r9_ack_clears_errors: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !frm_done) |=> (status[4:1] == 4'b0000) && !status[7]);

    a_r7_break_has_framing: assert property (@(posedge clk) disable iff (rst)
        status[4] |-> status[3]);
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_done  (frm_done),
    .data_rd   (data_rd),
    .status_rd (status_rd),
    .status    (status)
);

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b0;
    logic       rx_in = 1'b1;
    logic [7:0] line_cfg = 8'h03;
    logic       data_rd = 1'b0;
    logic       status_rd = 1'b0;
    logic       tx_empty_in = 1'b1;
    logic       tx_hold_empty_in = 1'b1;
    logic [7:0] rx_data;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tdiv   = 0;

    uart_rx_status u_dut (
        .clk              (clk),
        .rst              (rst),
        .tick_16x         (tick_16x),
        .rx_in            (rx_in),
        .line_cfg         (line_cfg),
        .data_rd          (data_rd),
        .status_rd        (status_rd),
        .tx_empty_in      (tx_empty_in),
        .tx_hold_empty_in (tx_hold_empty_in),
        .rx_data          (rx_data),
        .status           (status)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tdiv     <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick_16x <= (tdiv == TICK_DIV - 1);
        cycles   <= cycles + 1;
        if (cycles == WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic hold_bits(input int n);
        repeat (n * BIT_CLKS) @(negedge clk);
    endtask

    // Build and drive one frame from the requirement text.
    task automatic send_word(input logic [7:0] d, input bit flip_par, input bit stop_val);
        int   nb;
        logic [7:0] dm;
        logic p;
        nb = 5 + int'(line_cfg[1:0]);
        dm = d & 8'((1 << nb) - 1);
        if (line_cfg[5]) p = ~line_cfg[4];
        else             p = line_cfg[4] ? ^dm : ~^dm;
        @(negedge clk);
        rx_in = 1'b0; hold_bits(1);
        for (int i = 0; i < nb; i++) begin
            rx_in = d[i]; hold_bits(1);
        end
        if (line_cfg[3]) begin
            rx_in = p ^ flip_par; hold_bits(1);
        end
        rx_in = stop_val; hold_bits(1);
        rx_in = 1'b1; hold_bits(1);
    endtask

    task automatic pulse_data_rd;
        @(negedge clk) data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_status_rd;
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R11 reset status", status, 8'h60);
        check("R11 reset data", rx_data, 8'h00);
    endtask

    task automatic t_basic;
        line_cfg = 8'hC3;   // R12: transmitter-only bits set
        send_word(8'hA5, 1'b0, 1'b1);
        check("R1 R12 data 8N1", rx_data, 8'hA5);
        check("R3 R12 ready set", status, 8'h61);
        pulse_data_rd();
        check("R3 ready cleared by read", status, 8'h60);
    endtask

    task automatic t_lengths;
        for (int wl = 0; wl < 4; wl++) begin
            line_cfg = 8'(wl);
            send_word(8'hB6, 1'b0, 1'b1);
            check("R1 word length data", rx_data, 8'hB6 & 8'((1 << (5 + wl)) - 1));
            check("R1 word length status", status, 8'h61);
            pulse_data_rd();
        end
    endtask

    task automatic t_parity;
        line_cfg = 8'h1B;   // even
        send_word(8'h3C, 1'b0, 1'b1);
        check("R5 even good", status, 8'h61);
        pulse_data_rd();
        send_word(8'h3D, 1'b1, 1'b1);
        check("R5 R8 even bad", status, 8'hE5);
        pulse_status_rd();
        check("R9 ack keeps ready", status, 8'h61);
        check("R5 data kept", rx_data, 8'h3D);
        pulse_data_rd();
        line_cfg = 8'h0B;   // odd
        send_word(8'h07, 1'b0, 1'b1);
        check("R5 odd good", status, 8'h61);
        pulse_data_rd();
        send_word(8'h07, 1'b1, 1'b1);
        check("R5 odd bad", status, 8'hE5);
        pulse_status_rd(); pulse_data_rd();
        line_cfg = 8'h2B;   // fixed parity, expected bit 1
        send_word(8'h55, 1'b0, 1'b1);
        check("R5 fixed good", status, 8'h61);
        pulse_data_rd();
        send_word(8'h55, 1'b1, 1'b1);
        check("R5 fixed bad", status, 8'hE5);
        pulse_status_rd(); pulse_data_rd();
        check("R9 all cleared", status, 8'h60);
    endtask

    task automatic t_overrun;
        line_cfg = 8'h03;
        send_word(8'h11, 1'b0, 1'b1);
        send_word(8'h22, 1'b0, 1'b1);
        check("R4 newest word kept", rx_data, 8'h22);
        check("R4 overrun flag", status, 8'h63);
        pulse_status_rd();
        check("R9 overrun cleared", status, 8'h61);
        pulse_data_rd();
    endtask

    task automatic t_framing;
        line_cfg = 8'h03;
        send_word(8'h5A, 1'b0, 1'b0);
        check("R6 framing data", rx_data, 8'h5A);
        check("R6 R8 framing status", status, 8'hE9);
        pulse_status_rd(); pulse_data_rd();
    endtask

    task automatic t_break;
        line_cfg = 8'h03;
        @(negedge clk) rx_in = 1'b0;
        hold_bits(30);
        rx_in = 1'b1;
        hold_bits(2);
        check("R7 break data", rx_data, 8'h00);
        check("R7 break single word", status, 8'hF9);
        pulse_status_rd(); pulse_data_rd();
        send_word(8'h81, 1'b0, 1'b1);
        check("R7 recovers after break", rx_data, 8'h81);
        check("R7 clean status", status, 8'h61);
        pulse_data_rd();
    endtask

    task automatic t_glitch;
        @(negedge clk) rx_in = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rx_in = 1'b1;
        hold_bits(4);
        check("R2 glitch ignored", status, 8'h60);
        send_word(8'h3C, 1'b0, 1'b1);
        check("R2 frame after glitch", rx_data, 8'h3C);
        pulse_data_rd();
    endtask

    task automatic t_tx_mirror;
        @(negedge clk) begin tx_empty_in = 1'b0; tx_hold_empty_in = 1'b1; end
        #1 check("R10 mirror hold empty", status, 8'h20);
        tx_hold_empty_in = 1'b0;
        #1 check("R10 mirror both low", status, 8'h00);
        tx_empty_in = 1'b1;
        #1 check("R10 mirror tx empty", status, 8'h40);
        tx_hold_empty_in = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_lengths();
        t_parity();
        t_overrun();
        t_framing();
        t_break();
        t_glitch();
        t_tx_mirror();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule